// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits between a bus master and a slower downstream port. A write from the master is taken into a one-deep holding slot. Taking the write is the master's acknowledgement, so the master can go on at once while the block carries the write downstream by itself. The slot stays occupied until the downstream port returns a one-cycle completion pulse.

A read that the master presents while a write is still held is stalled by keeping the upstream ready low. It is forwarded only after the held write has completed downstream. Software can therefore use a throw-away read of any register as a fence that proves an earlier write has landed. Accesses are never reordered. No more than one access is in flight at a time, apart from the posted write itself. When the slot is empty, a read goes downstream after one register stage, and its data comes back one cycle after the downstream port returns it. The `wb_idle` output shows that no write is pending, so a barrier request can wait for the buffer to drain.

Both ports use a valid/ready request with address, write data and a byte-lane strobe. A request is taken on a clock edge where valid and ready are both high.

Top module: `pwb_top`

## Requirements
- R1: After reset, `up_ready` and `wb_idle` are 1, and `dn_valid` and `up_rsp_valid` are 0.
- R2: A write taken upstream (op bit `up_write`=1) raises `dn_valid` with `dn_write`=1 in the following cycle. It carries the same address, data and strobe, and no upstream response is produced for it.
- R3: While a write is held, `up_ready` stays 0, so a second write is stalled and at most one write is held.
- R4: A read (op bit `up_write`=0) is not taken while a write is held, and no read appears downstream until that write's completion pulse has been received.
- R5: The downstream request sequence (kind, address, data, strobe) equals the order in which the master's requests were taken.
- R6: A `dn_wr_done` pulse received while the held write has been handed downstream frees the slot: `wb_idle` and `up_ready` are 1 in the next cycle if no read is outstanding.
- R7: With the slot empty, a read taken in one cycle is presented downstream (`dn_valid`=1, `dn_write`=0) in the next cycle.
- R8: `dn_rd_valid` for the outstanding read produces `up_rsp_valid`=1 for exactly one cycle in the next cycle, with `up_rdata` equal to `dn_rdata`. A read is outstanding until that point, and `up_ready` stays 0 while it is.
- R9: `wb_idle` is 1 exactly when no write is held.
- R10: While `dn_valid` is 1 and `dn_ready` is 0, the downstream request fields are held stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_valid | input | 1 | Master request valid |
| up_ready | output | 1 | Block can take a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | AW | Request address |
| up_wdata | input | DW | Write data |
| up_wstrb | input | DW/8 | Write byte-lane strobe |
| up_rsp_valid | output | 1 | One-cycle read response pulse |
| up_rdata | output | DW | Read response data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream takes the request |
| dn_write | output | 1 | 1 = write, 0 = read |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_wstrb | output | DW/8 | Downstream byte-lane strobe |
| dn_wr_done | input | 1 | One-cycle pulse: handed-down write has completed |
| dn_rd_valid | input | 1 | One-cycle pulse: read data valid |
| dn_rdata | input | DW | Downstream read data |
| wb_idle | output | 1 | No write is held |

## Verification
On every cycle the assertions check several local rules: a write is never taken into an occupied slot, a completion pulse frees the slot, the downstream request holds still under back-pressure, only one source drives the downstream port at a time, no read goes downstream while a write is held, and read and response timing is met. The ordering guarantee, the use of a read as a fence after a write, and the exact cycles in which `up_ready` and `wb_idle` recover can only be shown by the bench's scenarios. Its reference model follows back-to-back write/read, write/write and random traffic with downstream stalls and varied completion delays.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } pwb_op_e;
endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwb_wr_slot.sv
module pwb_wr_slot #(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] strb_i,
  input  logic          grant,
  input  logic          done_i,
  output logic          full_o,
  output logic          issue_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [SW-1:0] strb_o
);
  logic full_q, full_d;
  logic sent_q, sent_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [SW-1:0] strb_q;

  always_comb begin
    full_d = full_q;
    sent_d = sent_q;
    if (sent_q && done_i) begin
      full_d = 1'b0;
      sent_d = 1'b0;
    end
    if (grant) sent_d = 1'b1;
    if (take) begin
      full_d = 1'b1;
      sent_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      full_q <= full_d;
      sent_q <= sent_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q <= addr_i;
      data_q <= data_i;
      strb_q <= strb_i;
    end
  end

  assign full_o  = full_q;
  assign issue_o = full_q && !sent_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign strb_o  = strb_q;

  // R3: the slot never takes a write while occupied
  a_r3_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !full_q);
  // R6: completion of the handed-down write frees the slot
  a_r6_free_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_q && done_i) |=> !full_q);
  // R2: a taken write is offered downstream next cycle
  a_r2_posted_issue: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> issue_o);
  // R10: request held still under back-pressure
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && !grant) |=> (issue_o && $stable(addr_o) && $stable(data_o) && $stable(strb_o)));
endmodule

// File: rtl/pwb_rd_slot.sv
module pwb_rd_slot #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_i,
  input  logic          grant,
  input  logic          rsp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic          issue_o,
  output logic [AW-1:0] addr_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rdata_o
);
  logic busy_q, busy_d;
  logic sent_q, sent_d;
  logic rsp_q, rsp_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic          back;

  assign back = sent_q && rsp_i;

  always_comb begin
    busy_d = busy_q;
    sent_d = sent_q;
    rsp_d  = back;
    if (back) begin
      busy_d = 1'b0;
      sent_d = 1'b0;
    end
    if (grant) sent_d = 1'b1;
    if (take) begin
      busy_d = 1'b1;
      sent_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      rsp_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sent_q <= sent_d;
      rsp_q  <= rsp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) addr_q <= addr_i;
    if (back) rdata_q <= rdata_i;
  end

  assign busy_o      = busy_q;
  assign issue_o     = busy_q && !sent_q;
  assign addr_o      = addr_q;
  assign rsp_valid_o = rsp_q;
  assign rdata_o     = rdata_q;

  // R7: a taken read is offered downstream next cycle
  a_r7_read_issue: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> issue_o);
  // R8: returned data reaches the master next cycle, as a single pulse
  a_r8_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    back |=> (rsp_valid_o && !busy_o));
  a_r8_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);
  // R10: read request held still under back-pressure
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && !grant) |=> (issue_o && $stable(addr_o)));
endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  input  logic [SW-1:0] up_wstrb,
  output logic          up_rsp_valid,
  output logic [DW-1:0] up_rdata,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  output logic [SW-1:0] dn_wstrb,
  input  logic          dn_wr_done,
  input  logic          dn_rd_valid,
  input  logic [DW-1:0] dn_rdata,
  output logic          wb_idle
);
  import pwb_pkg::*;

  logic rst_n;
  logic wr_full, wr_issue, rd_busy, rd_issue;
  logic wr_take, rd_take, wr_grant, rd_grant;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [SW-1:0] wr_strb;
  pwb_op_e op;

  pwb_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  assign op       = pwb_op_e'(up_write);
  assign up_ready = !wr_full && !rd_busy;
  assign wr_take  = up_valid && up_ready && (op == OP_WRITE);
  assign rd_take  = up_valid && up_ready && (op == OP_READ);
  assign wr_grant = wr_issue && dn_ready;
  assign rd_grant = rd_issue && dn_ready;

  pwb_wr_slot #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .take(wr_take),
    .addr_i(up_addr), .data_i(up_wdata), .strb_i(up_wstrb),
    .grant(wr_grant), .done_i(dn_wr_done),
    .full_o(wr_full), .issue_o(wr_issue),
    .addr_o(wr_addr), .data_o(wr_data), .strb_o(wr_strb)
  );

  pwb_rd_slot #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .take(rd_take), .addr_i(up_addr),
    .grant(rd_grant), .rsp_i(dn_rd_valid), .rdata_i(dn_rdata),
    .busy_o(rd_busy), .issue_o(rd_issue), .addr_o(rd_addr),
    .rsp_valid_o(up_rsp_valid), .rdata_o(up_rdata)
  );

  assign dn_valid = wr_issue || rd_issue;
  assign dn_write = wr_issue;
  assign dn_addr  = wr_issue ? wr_addr : rd_addr;
  assign dn_wdata = wr_data;
  assign dn_wstrb = wr_strb;
  assign wb_idle  = !wr_full;

  // R5: only one source drives the downstream port at a time
  a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_issue, rd_issue}));
  // R4: no read goes downstream while a write is held
  a_r4_read_fenced: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_write) |-> wb_idle);
  // R9: idle falls after a write is taken
  a_r9_idle_falls: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !wb_idle);
  // R1: nothing offered downstream in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!dn_valid && !up_rsp_valid));
endmodule

// File: tb/pwb_top_tb_top.sv
module pwb_top_tb_top;
  localparam int  AW = 16;
  localparam int  DW = 32;
  localparam int  SW = DW / 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic up_valid = 1'b0, up_write = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic [SW-1:0] up_wstrb = '0;
  logic dn_ready = 1'b0, dn_wr_done = 1'b0, dn_rd_valid = 1'b0;
  logic [DW-1:0] dn_rdata = '0;
  logic up_ready, up_rsp_valid, dn_valid, dn_write, wb_idle;
  logic [DW-1:0] up_rdata, dn_wdata;
  logic [AW-1:0] dn_addr;
  logic [SW-1:0] dn_wstrb;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_top #(.AW(AW), .DW(DW)) dut_i (.*);

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [SW-1:0] strb;
  } op_t;

  op_t script[$];   // master's requests still to be presented
  op_t expq[$];     // taken, not yet seen downstream
  int  n_cmp = 0, n_bad = 0;

  // reference model state
  bit m_wr, m_wr_sent, m_rd, m_rd_sent, m_rsp;
  logic [DW-1:0] m_rsp_data;
  // downstream responder state
  int wr_wait = -1, rd_wait = -1, done_min = 1, done_span = 1;
  int ready_pct = 100;
  bit prev_stall;
  op_t prev_req;

  function automatic logic [DW-1:0] rd_fn(logic [AW-1:0] a);
    return {a ^ 16'h5a5a, ~a};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    bit acc, exp_dv;
    op_t head;
    @(negedge clk);
    // compare against the model
    chk("R3 R4 R8 up_ready", up_ready, !(m_wr || m_rd));
    chk("R9 R6 wb_idle", wb_idle, !m_wr);
    chk("R8 up_rsp_valid", up_rsp_valid, m_rsp);
    if (m_rsp) chk("R8 up_rdata", up_rdata, m_rsp_data);
    exp_dv = (m_wr && !m_wr_sent) || (m_rd && !m_rd_sent);
    chk("R2 R4 R7 dn_valid", dn_valid, exp_dv);
    if (dn_valid && exp_dv && expq.size() > 0) begin
      head = expq[0];
      chk("R5 dn_write", dn_write, head.wr);
      chk("R5 dn_addr", dn_addr, head.addr);
      if (head.wr) begin
        chk("R2 dn_wdata", dn_wdata, head.data);
        chk("R2 dn_wstrb", dn_wstrb, head.strb);
      end
    end
    if (prev_stall && dn_valid) begin
      chk("R10 addr held", dn_addr, prev_req.addr);
      chk("R10 kind held", dn_write, prev_req.wr);
    end
    // drive master
    if (script.size() > 0) begin
      up_valid = 1'b1;
      up_write = script[0].wr;
      up_addr  = script[0].addr;
      up_wdata = script[0].data;
      up_wstrb = script[0].strb;
    end else begin
      up_valid = 1'b0;
    end
    // drive downstream responder
    dn_ready = ($urandom_range(99) < ready_pct);
    dn_wr_done = (wr_wait == 0);
    dn_rd_valid = (rd_wait == 0);
    dn_rdata = rd_fn(prev_req.addr);
    if (wr_wait >= 0) wr_wait--;
    if (rd_wait >= 0) rd_wait--;
    if (dn_valid && dn_ready) begin
      if (dn_write) wr_wait = done_min - 1 + $urandom_range(done_span - 1);
      else          rd_wait = done_min - 1 + $urandom_range(done_span - 1);
    end
    prev_stall = dn_valid && !dn_ready;
    prev_req.wr = dn_write;
    prev_req.addr = dn_addr;
    if (dn_rd_valid) dn_rdata = rd_fn(expq_last_rd);
    // advance model to the coming edge
    acc = up_valid && !(m_wr || m_rd);
    m_rsp = m_rd_sent && dn_rd_valid;
    m_rsp_data = dn_rdata;
    if (m_wr_sent && dn_wr_done) begin m_wr = 0; m_wr_sent = 0; end
    if (m_rd_sent && dn_rd_valid) begin m_rd = 0; m_rd_sent = 0; end
    if (exp_dv && dn_ready && expq.size() > 0) begin
      if (expq[0].wr) m_wr_sent = 1;
      else begin m_rd_sent = 1; expq_last_rd = expq[0].addr; end
      void'(expq.pop_front());
    end
    if (acc) begin
      expq.push_back(script[0]);
      if (script[0].wr) m_wr = 1; else m_rd = 1;
      void'(script.pop_front());
    end
  endtask

  logic [AW-1:0] expq_last_rd = '0;

  function automatic op_t mk(bit wr, int a, int d, int s);
    op_t o;
    o.wr = wr; o.addr = AW'(a); o.data = DW'(d); o.strb = SW'(s);
    return o;
  endfunction

  task automatic drain(int extra);
    int guard = 0;
    while ((script.size() > 0 || m_wr || m_rd) && guard < 5000) begin
      cycle(); guard++;
    end
    if (guard >= 5000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected drained");
    end
    repeat (extra) cycle();
  endtask

  initial begin
    m_wr = 0; m_wr_sent = 0; m_rd = 0; m_rd_sent = 0; m_rsp = 0;
    m_rsp_data = '0; prev_stall = 0; prev_req = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 up_ready", up_ready, 1);
    chk("R1 wb_idle", wb_idle, 1);
    chk("R1 dn_valid", dn_valid, 0);
    chk("R1 up_rsp_valid", up_rsp_valid, 0);
    // single posted write, slow completion (R2 R6 R9)
    done_min = 4; done_span = 1;
    script.push_back(mk(1, 'h0010, 'hcafe0001, 'hf));
    drain(2);
    // write then read fence (R4 R5)
    script.push_back(mk(1, 'h0020, 'h11112222, 'h3));
    script.push_back(mk(0, 'h0020, 0, 0));
    drain(2);
    // back-to-back writes (R3)
    done_min = 2;
    script.push_back(mk(1, 'h0030, 'h0a0a0a0a, 'h1));
    script.push_back(mk(1, 'h0034, 'h0b0b0b0b, 'hc));
    script.push_back(mk(0, 'h0040, 0, 0));
    drain(2);
    // reads with empty slot (R7 R8)
    done_min = 1;
    script.push_back(mk(0, 'h0100, 0, 0));
    script.push_back(mk(0, 'h0104, 0, 0));
    drain(2);
    // random traffic with back-pressure (R10 R5)
    ready_pct = 40; done_span = 5;
    for (int i = 0; i < 400; i++)
      script.push_back(mk($urandom_range(1), $urandom_range(16'hffff),
                          $urandom, $urandom_range(15)));
    drain(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule